// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one synchronous DRAM read or write burst. A one-cycle start pulse captures a 10-bit start column together with the burst settings that the controller holds in its mode register: a length code and an ordering bit. From the next cycle onward the block presents one column per clock. It raises a valid strobe for each beat and a last-beat flag on the final beat.

Finite bursts of 2, 4 or 8 beats stay inside the aligned block of that size. The sequence there is either sequential with wrap, or interleaved, where the beat index is XORed into the low bits. A full-page burst walks the whole row modulo 1024 and runs until a stop request arrives. A stop request ends a burst of any length. A new start may arrive on any cycle, including during a burst, and it replaces the running sequence.

Top module: `burst_colgen`

## Requirements
- R1: After reset is released and before any start pulse, `valid_o` and `last_o` are low.
- R2: When `start_i` is high at a rising edge, the output after that edge is valid and `col_o` equals the `start_col_i` sampled at that edge.
- R3: The length code `len_code_i` is decoded as 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8 and 3'b111 = full page. The codes 3'b100, 3'b101 and 3'b110 behave as 1 beat.
- R4: With `interleave_i` = 0 and a length L of 2, 4 or 8, beat j carries the start column with its low log2(L) bits replaced by (start low bits + j) mod L. The upper bits never change during a burst.
- R5: With `interleave_i` = 1 and a length L of 2, 4 or 8, beat j carries the start column with its low log2(L) bits replaced by (start low bits XOR j).
- R6: A full-page burst gives beat j = (start + j) mod 1024 whatever the value of `interleave_i`. It never raises `last_o` on its own, not even across the wrap from 1023 to 0.
- R7: `last_o` is high only together with `valid_o`. It is high on the final beat of a finite burst, and `valid_o` is low on the cycle after that beat unless a new start was sampled.
- R8: When `stop_i` is high at an edge during an active burst whose current beat is not the last, the next beat is shown with `last_o` high and the burst then ends.
- R9: `stop_i` has no effect when no burst is active, and none when it is sampled at the same edge as `start_i`.
- R10: A start sampled during an active burst replaces the sequence: the next output is beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse that captures column and settings |
| start_col_i | input | 10 | First column of the burst |
| len_code_i | input | 3 | Burst length code (see R3) |
| interleave_i | input | 1 | 1 selects interleaved ordering for finite bursts |
| stop_i | input | 1 | Request to end the running burst |
| col_o | output | 10 | Column of the current beat |
| valid_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | Current beat is the final one |

## Verification
The bench starts bursts from columns that are not aligned, so the wrap inside a 4- or 8-beat block is exercised. A design that carried into the upper bits would leave the block, and one that used addition for interleave would give 13,14,15 where 13,12,15 is due. A full-page burst runs past 1024 beats and must raise no last flag at the wrap; a design that compared the beat counter with the full mask would end the burst at beat 1023. Stop requests arrive mid-burst, while idle and at the same edge as a start. A design that let a stop slip through in those cases would cut bursts short or emit a stray last flag. A restart in the middle of an 8-beat burst checks that no stale beat of the old sequence leaks out.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int COL_W  = 10;
  localparam int CODE_W = 3;

  typedef logic [COL_W-1:0] col_t;

  typedef enum logic [CODE_W-1:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE  = 3'd7
  } bl_code_e;

  // Mask of the column bits that move during a burst (R3)
  function automatic col_t wrap_mask(logic [CODE_W-1:0] code);
    case (code)
      BL_TWO:   return col_t'(1);
      BL_FOUR:  return col_t'(3);
      BL_EIGHT: return col_t'(7);
      BL_PAGE:  return '1;
      default:  return '0;
    endcase
  endfunction

  // Column of beat idx: upper bits from base, low bits by order (R4, R5, R6)
  function automatic col_t beat_col(col_t base, col_t idx, col_t mask, logic xor_mode);
    col_t low;
    low = xor_mode ? (base ^ idx) : (base + idx);
    return (base & ~mask) | (low & mask);
  endfunction
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              interleave_i,
  output col_t              mask_o,
  output logic              page_o,
  output logic              xor_o
);
  always_comb begin
    mask_o = wrap_mask(code_i);
    page_o = (code_i == BL_PAGE);
    // full page always runs sequentially
    xor_o  = interleave_i & ~page_o;
  end
endmodule

// File: rtl/burst_beat_ctl.sv
module burst_beat_ctl
  import burst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  col_t start_col_i,
  input  col_t mask_i,
  input  logic page_i,
  input  logic xor_i,
  output logic active_o,
  output col_t base_o,
  output col_t idx_o,
  output col_t mask_o,
  output logic page_o,
  output logic xor_o,
  output logic final_o
);
  logic stop_q;
  logic count_end;

  assign count_end = ~page_o & (idx_o == mask_o);
  assign final_o   = active_o & (stop_q | count_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      base_o   <= '0;
      idx_o    <= '0;
      mask_o   <= '0;
      page_o   <= 1'b0;
      xor_o    <= 1'b0;
      stop_q   <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      base_o   <= start_col_i;
      idx_o    <= '0;
      mask_o   <= mask_i;
      page_o   <= page_i;
      xor_o    <= xor_i;
      stop_q   <= 1'b0;
    end else if (active_o) begin
      if (final_o) begin
        active_o <= 1'b0;
        stop_q   <= 1'b0;
      end else begin
        idx_o  <= idx_o + col_t'(1);
        stop_q <= stop_i;
      end
    end
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_pkg::*;
(
  input  col_t base_i,
  input  col_t idx_i,
  input  col_t mask_i,
  input  logic xor_i,
  output col_t col_o
);
  assign col_o = beat_col(base_i, idx_i, mask_i, xor_i);
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              interleave_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o
);
  col_t dec_mask;
  logic dec_page;
  logic dec_xor;
  logic burst_active;
  col_t base_q;
  col_t idx_q;
  col_t len_mask;
  logic page_q;
  logic xor_q;
  logic final_beat;

  burst_len_decode u_dec (
    .code_i       (len_code_i),
    .interleave_i (interleave_i),
    .mask_o       (dec_mask),
    .page_o       (dec_page),
    .xor_o        (dec_xor)
  );

  burst_beat_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .page_i      (dec_page),
    .xor_i       (dec_xor),
    .active_o    (burst_active),
    .base_o      (base_q),
    .idx_o       (idx_q),
    .mask_o      (len_mask),
    .page_o      (page_q),
    .xor_o       (xor_q),
    .final_o     (final_beat)
  );

  burst_col_map u_map (
    .base_i (base_q),
    .idx_i  (idx_q),
    .mask_i (len_mask),
    .xor_i  (xor_q),
    .col_o  (col_o)
  );

  assign valid_o = burst_active;
  assign last_o  = final_beat;
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk
  import burst_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input col_t start_col_i,
  input col_t col_o,
  input logic valid_o,
  input logic last_o,
  input col_t mask_q,
  input logic page_q,
  input logic xor_q
);
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o && col_o == $past(start_col_i));

  assert_block_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && !start_i |=> ((col_o ^ $past(col_o)) & ~$past(mask_q)) == '0);

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && !start_i && !xor_q |=> ((col_o - $past(col_o)) & $past(mask_q)) == col_t'(1));

  assert_page_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && page_q && !last_o && !stop_i && !start_i |=> valid_o && !last_o);

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && last_o && !start_i |=> !valid_o);

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && stop_i && !start_i |=> valid_o && last_o);

  assert_idle_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o && !start_i |=> !valid_o);
endmodule

bind burst_colgen burst_colgen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .start_col_i (start_col_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .mask_q      (len_mask),
  .page_q      (page_q),
  .xor_q       (xor_q)
);

// File: tb/sim_burst_colgen.sv
module sim_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [9:0] col_o;
  logic       valid_o;
  logic       last_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int    col;
    bit    last;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  burst_colgen u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int blen(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 1024;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int s, int code, int il, int j);
    int L = blen(code);
    int off = s % L;
    if (code == 7) return (s + j) % 1024;
    if (il != 0) return (s - off) + (off ^ j);
    return (s - off) + ((off + j) % L);
  endfunction

  // stopk: beat index that the stop makes last (0 = none); cut: beats shown before a restart
  task automatic burst(int s, int code, int il, int stopk, int cut, bit stop_with_start, string tag);
    int n;
    int waits;
    n = (cut > 0) ? cut : ((stopk > 0) ? stopk + 1 : blen(code));
    for (int j = 0; j < n; j++) begin
      exp_t e;
      e.col  = exp_col(s, code, il, j);
      e.last = (cut == 0) && (j == n - 1);
      e.tag  = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    start_i      = 1'b1;
    start_col_i  = 10'(s);
    len_code_i   = 3'(code);
    interleave_i = il[0];
    stop_i       = stop_with_start;
    waits = (cut > 0) ? cut - 1 : n + 1;
    for (int i = 1; i <= waits; i++) begin
      @(negedge clk);
      if (i == 1) start_i = 1'b0;
      stop_i = (i == stopk);
    end
    if (cut == 0) stop_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done && valid_o) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected beat (R7/R9): actual col=%0d last=%0b expected no beat", col_o, last_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (int'(col_o) != e.col || last_o != e.last) begin
          errors++;
          $display("FAIL %s: actual col=%0d last=%0b expected col=%0d last=%0b",
                   e.tag, col_o, last_o, e.col, e.last);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || last_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: actual valid=%0b last=%0b expected 0 0", valid_o, last_o);
    end

    burst(37, 0, 0, 0, 0, 0, "R3 one beat");
    burst(5, 1, 0, 0, 0, 0, "R3/R4 two beats");
    burst(6, 2, 0, 0, 0, 0, "R4 seq four from 6");
    burst(13, 3, 0, 0, 0, 0, "R4 seq eight from 13");
    burst(6, 2, 1, 0, 0, 0, "R5 interleave four from 6");
    burst(13, 3, 1, 0, 0, 0, "R5 interleave eight from 13");
    burst(517, 5, 1, 0, 0, 0, "R3 reserved code acts as one");
    burst(1020, 7, 0, 6, 0, 0, "R6/R8 page wrap with stop");
    burst(1021, 7, 1, 4, 0, 0, "R6 page ignores interleave");
    burst(0, 7, 0, 0, 1030, 0, "R6 page no last past 1024");
    burst(200, 3, 0, 2, 0, 0, "R8 stop mid eight");
    burst(40, 2, 0, 0, 0, 1, "R9 stop with start ignored");
    burst(3, 3, 0, 0, 3, 0, "R10 restart cut");
    burst(100, 1, 1, 0, 0, 0, "R10 restart new burst");

    // R9: stop while idle has no effect
    @(negedge clk);
    stop_i = 1'b1;
    repeat (3) @(negedge clk);
    stop_i = 1'b0;
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle stop: actual valid=%0b expected 0", valid_o);
    end
    burst(777, 2, 0, 0, 0, 0, "R7 finite burst after idle stop");

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R7 missing beats: actual remaining=%0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule